// File: doc/BRIEF.md
# Flag-Aware Register Rename Table

This block is the rename stage of an out-of-order integer core in which every physical register carries its integer result and the six arithmetic condition flags of the micro-op that produced it. A micro-op that writes a result, flags or both takes a single physical register. The flags are renamed by pointing at that register, not by allocating a separate flag register. Two flag slots are kept: one follows the producer of the carry group and one follows the producer of the remaining five flags. A micro-op that changes only one group moves only that slot, and no merge micro-op is needed.

The block holds a speculative map, which rename reads and writes, and a retirement map, which the retire port advances in program order. Every physical register has a reference count that covers the retirement integer entries and retirement flag slots pointing at it. A register goes back to the free list only when a retire brings its count to zero, so a register that still backs live flags is never reused. A flush copies the retirement map into the speculative map in one cycle and returns every register that was allocated but not retired. When no register is free, rename stalls.

Top module: `flag_rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i, both flag slots point at physical register 0, and the first allocation returns physical register 16.
- R2: The source tags and both flag-slot tags on the rename outputs come from the speculative map as it stands before the current request is applied.
- R3: A request that writes a result or any flag group allocates exactly one physical register. That register is the lowest-numbered free register. A request that writes neither allocates nothing.
- R4: The write-flags mask has bit 0 for the carry slot and bit 1 for the other-flags slot. Each slot moves to the new register only when its bit is set. The integer entry moves only when the destination is valid.
- R5: A retire moves the retirement entries in the same way as rename moved the speculative ones. A register returns to the free list when a retire drops its reference count to zero. A register is never released twice.
- R6: A register that a retirement flag slot still references is not freed, even after its integer mapping has been overwritten and retired.
- R7: A flush restores the speculative map and both flag slots from the retirement map in one cycle and frees every register that is allocated but not retired. Rename is not ready during the flush cycle.
- R8: When the free list is empty, ready is low and a valid request changes neither the speculative map nor the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard speculative state |
| ren_valid_i | input | 1 | Rename request valid |
| ren_src_a_i | input | 4 | Architectural source A |
| ren_src_b_i | input | 4 | Architectural source B |
| ren_dst_valid_i | input | 1 | Request writes an integer result |
| ren_dst_i | input | 4 | Architectural destination |
| ren_wflags_i | input | 2 | Flag write mask: bit 0 carry, bit 1 other flags |
| ren_ready_o | output | 1 | Rename can accept a request |
| ren_psrc_a_o | output | 6 | Physical tag for source A |
| ren_psrc_b_o | output | 6 | Physical tag for source B |
| ren_pflag_c_o | output | 6 | Physical tag holding the carry group |
| ren_pflag_o_o | output | 6 | Physical tag holding the other flags |
| ren_pdst_o | output | 6 | Allocated physical destination |
| ret_valid_i | input | 1 | Retire valid |
| ret_dst_valid_i | input | 1 | Retiring op wrote an integer result |
| ret_dst_i | input | 4 | Retiring architectural destination |
| ret_wflags_i | input | 2 | Retiring flag write mask, same encoding |
| ret_pdst_i | input | 6 | Retiring physical destination |

## Verification
A miscounted reference, or a flag slot that moves when it should not, does not show up at once. It shows up later as a physical tag handed out while a map entry or flag slot still names it, or as a tag missing from the ascending allocation order. The bench therefore renames, retires and then reallocates, and checks each allocated tag and each flag-slot tag as it appears. A bad flush shows up on the first source lookup after it. A stall leak shows up as a changed mapping on the cycle after a refused request.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned NUM_ARCH_DEF = 16;
  localparam int unsigned NUM_PHYS_DEF = 64;
  localparam int unsigned FLG_W        = 2;
  localparam int unsigned FLG_CARRY    = 0;  // mask bit for carry slot
  localparam int unsigned FLG_REST     = 1;  // mask bit for the other five flags
endpackage

// File: rtl/frt_free_list.sv
module frt_free_list #(
  parameter int unsigned NUM_ARCH = frt_pkg::NUM_ARCH_DEF,
  parameter int unsigned NUM_PHYS = frt_pkg::NUM_PHYS_DEF,
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic                flush_i,
  input  logic [NUM_PHYS-1:0] live_i,
  input  logic [NUM_PHYS-1:0] release_i,
  output logic                avail_o,
  output logic [PHYS_W-1:0]   alloc_tag_o
);
  logic [NUM_PHYS-1:0] free_q, free_d, alloc_oh;

  always_comb begin
    alloc_tag_o = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag_o = PHYS_W'(i);
    end
  end

  assign avail_o  = |free_q;
  assign alloc_oh = alloc_i ? (NUM_PHYS'(1) << alloc_tag_o) : '0;

  always_comb begin
    if (flush_i) free_d = ~live_i;
    else         free_d = (free_q & ~alloc_oh) | release_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
    end else begin
      free_q <= free_d;
    end
  end

  AST_ALLOC_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (free_q != '0)); // R8
  AST_RELEASE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i & free_q) == '0); // R5
endmodule

// File: rtl/frt_ret_map.sv
module frt_ret_map #(
  parameter int unsigned NUM_ARCH = frt_pkg::NUM_ARCH_DEF,
  parameter int unsigned NUM_PHYS = frt_pkg::NUM_PHYS_DEF,
  localparam int unsigned ARCH_W  = $clog2(NUM_ARCH),
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS),
  localparam int unsigned CNT_W   = $clog2(NUM_ARCH + 3)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ret_valid_i,
  input  logic                             ret_dst_valid_i,
  input  logic [ARCH_W-1:0]                ret_dst_i,
  input  logic [frt_pkg::FLG_W-1:0]        ret_wflags_i,
  input  logic [PHYS_W-1:0]                ret_pdst_i,
  output logic [NUM_ARCH-1:0][PHYS_W-1:0]  map_q_o,
  output logic [PHYS_W-1:0]                flg_c_q_o,
  output logic [PHYS_W-1:0]                flg_o_q_o,
  output logic [NUM_ARCH-1:0][PHYS_W-1:0]  map_d_o,
  output logic [PHYS_W-1:0]                flg_c_d_o,
  output logic [PHYS_W-1:0]                flg_o_d_o,
  output logic [NUM_PHYS-1:0]              live_d_o,
  output logic [NUM_PHYS-1:0]              release_o
);
  import frt_pkg::*;

  logic [NUM_PHYS-1:0][CNT_W-1:0] cnt_all;
  logic [PHYS_W-1:0] old_int;
  logic w_int, w_c, w_o;

  assign w_int   = ret_valid_i && ret_dst_valid_i;
  assign w_c     = ret_valid_i && ret_wflags_i[FLG_CARRY];
  assign w_o     = ret_valid_i && ret_wflags_i[FLG_REST];
  assign old_int = map_q_o[ret_dst_i];

  always_comb begin
    map_d_o   = map_q_o;
    flg_c_d_o = flg_c_q_o;
    flg_o_d_o = flg_o_q_o;
    if (w_int) map_d_o[ret_dst_i] = ret_pdst_i;
    if (w_c)   flg_c_d_o = ret_pdst_i;
    if (w_o)   flg_o_d_o = ret_pdst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q_o[i] <= PHYS_W'(i);
      flg_c_q_o <= '0;
      flg_o_q_o <= '0;
    end else begin
      map_q_o   <= map_d_o;
      flg_c_q_o <= flg_c_d_o;
      flg_o_q_o <= flg_o_d_o;
    end
  end

  // one reference counter per physical register
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_cnt
    localparam logic [CNT_W-1:0] RST_CNT =
      CNT_W'((p < NUM_ARCH ? 1 : 0) + (p == 0 ? 2 : 0));
    logic [CNT_W-1:0] cnt_q, cnt_d, inc, dec;

    always_comb begin
      inc = CNT_W'(w_int && (ret_pdst_i == PHYS_W'(p)))
          + CNT_W'(w_c   && (ret_pdst_i == PHYS_W'(p)))
          + CNT_W'(w_o   && (ret_pdst_i == PHYS_W'(p)));
      dec = CNT_W'(w_int && (old_int   == PHYS_W'(p)))
          + CNT_W'(w_c   && (flg_c_q_o == PHYS_W'(p)))
          + CNT_W'(w_o   && (flg_o_q_o == PHYS_W'(p)));
      cnt_d = cnt_q + inc - dec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= RST_CNT;
      else         cnt_q <= cnt_d;
    end

    assign cnt_all[p]   = cnt_q;
    assign live_d_o[p]  = (cnt_d != '0);
    assign release_o[p] = (cnt_q != '0) && (cnt_d == '0);
  end

  AST_FLAGS_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_all[flg_c_q_o] != '0) && (cnt_all[flg_o_q_o] != '0)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_int |-> (cnt_all[old_int] != '0)); // R5
endmodule

// File: rtl/frt_spec_map.sv
module frt_spec_map #(
  parameter int unsigned NUM_ARCH = frt_pkg::NUM_ARCH_DEF,
  parameter int unsigned NUM_PHYS = frt_pkg::NUM_PHYS_DEF,
  localparam int unsigned ARCH_W  = $clog2(NUM_ARCH),
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic                             dst_valid_i,
  input  logic [ARCH_W-1:0]                dst_i,
  input  logic [frt_pkg::FLG_W-1:0]        wflags_i,
  input  logic [PHYS_W-1:0]                pdst_i,
  input  logic                             flush_i,
  input  logic [NUM_ARCH-1:0][PHYS_W-1:0]  ret_map_i,
  input  logic [PHYS_W-1:0]                ret_flg_c_i,
  input  logic [PHYS_W-1:0]                ret_flg_o_i,
  output logic [NUM_ARCH-1:0][PHYS_W-1:0]  map_o,
  output logic [PHYS_W-1:0]                flg_c_o,
  output logic [PHYS_W-1:0]                flg_o_o
);
  import frt_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_o[i] <= PHYS_W'(i);
      flg_c_o <= '0;
      flg_o_o <= '0;
    end else if (flush_i) begin
      map_o   <= ret_map_i;
      flg_c_o <= ret_flg_c_i;
      flg_o_o <= ret_flg_o_i;
    end else if (wr_i) begin
      if (dst_valid_i)          map_o[dst_i] <= pdst_i;
      if (wflags_i[FLG_CARRY])  flg_c_o      <= pdst_i;
      if (wflags_i[FLG_REST])   flg_o_o      <= pdst_i;
    end
  end
endmodule

// File: rtl/flag_rename_table.sv
module flag_rename_table #(
  parameter int unsigned NUM_ARCH = frt_pkg::NUM_ARCH_DEF,
  parameter int unsigned NUM_PHYS = frt_pkg::NUM_PHYS_DEF,
  localparam int unsigned ARCH_W  = $clog2(NUM_ARCH),
  localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      ren_valid_i,
  input  logic [ARCH_W-1:0]         ren_src_a_i,
  input  logic [ARCH_W-1:0]         ren_src_b_i,
  input  logic                      ren_dst_valid_i,
  input  logic [ARCH_W-1:0]         ren_dst_i,
  input  logic [frt_pkg::FLG_W-1:0] ren_wflags_i,
  output logic                      ren_ready_o,
  output logic [PHYS_W-1:0]         ren_psrc_a_o,
  output logic [PHYS_W-1:0]         ren_psrc_b_o,
  output logic [PHYS_W-1:0]         ren_pflag_c_o,
  output logic [PHYS_W-1:0]         ren_pflag_o_o,
  output logic [PHYS_W-1:0]         ren_pdst_o,
  input  logic                      ret_valid_i,
  input  logic                      ret_dst_valid_i,
  input  logic [ARCH_W-1:0]         ret_dst_i,
  input  logic [frt_pkg::FLG_W-1:0] ret_wflags_i,
  input  logic [PHYS_W-1:0]         ret_pdst_i
);
  import frt_pkg::*;

  logic [NUM_ARCH-1:0][PHYS_W-1:0] spec_map, ret_map_q, ret_map_d;
  logic [PHYS_W-1:0] spec_c, spec_o, ret_c_q, ret_o_q, ret_c_d, ret_o_d;
  logic [NUM_PHYS-1:0] live_d, release_v;
  logic avail, fire, needs_alloc, alloc;

  assign needs_alloc = ren_dst_valid_i || (ren_wflags_i != '0);
  assign ren_ready_o = avail && !flush_i;
  assign fire        = ren_valid_i && ren_ready_o;
  assign alloc       = fire && needs_alloc;

  assign ren_psrc_a_o  = spec_map[ren_src_a_i];
  assign ren_psrc_b_o  = spec_map[ren_src_b_i];
  assign ren_pflag_c_o = spec_c;
  assign ren_pflag_o_o = spec_o;

  frt_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i, .rst_ni,
    .alloc_i     (alloc),
    .flush_i     (flush_i),
    .live_i      (live_d),
    .release_i   (release_v),
    .avail_o     (avail),
    .alloc_tag_o (ren_pdst_o)
  );

  frt_spec_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_spec (
    .clk_i, .rst_ni,
    .wr_i        (alloc),
    .dst_valid_i (ren_dst_valid_i),
    .dst_i       (ren_dst_i),
    .wflags_i    (ren_wflags_i),
    .pdst_i      (ren_pdst_o),
    .flush_i     (flush_i),
    .ret_map_i   (ret_map_d),
    .ret_flg_c_i (ret_c_d),
    .ret_flg_o_i (ret_o_d),
    .map_o       (spec_map),
    .flg_c_o     (spec_c),
    .flg_o_o     (spec_o)
  );

  frt_ret_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_ret (
    .clk_i, .rst_ni,
    .ret_valid_i, .ret_dst_valid_i, .ret_dst_i, .ret_wflags_i, .ret_pdst_i,
    .map_q_o   (ret_map_q),
    .flg_c_q_o (ret_c_q),
    .flg_o_q_o (ret_o_q),
    .map_d_o   (ret_map_d),
    .flg_c_d_o (ret_c_d),
    .flg_o_d_o (ret_o_d),
    .live_d_o  (live_d),
    .release_o (release_v)
  );

  AST_FLUSH_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (spec_map == ret_map_q && spec_c == ret_c_q && spec_o == ret_o_q)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && !avail && !flush_i) |=> ($stable(spec_map) && $stable(spec_c) && $stable(spec_o))); // R8
  AST_CARRY_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc && ren_wflags_i[FLG_CARRY]) |=> (spec_c == $past(ren_pdst_o))); // R4
  AST_REST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ren_wflags_i[FLG_REST]) |=> $stable(spec_o)); // R4
endmodule

// File: tb/flag_rename_table_tb.sv
`timescale 1ns/1ps
module flag_rename_table_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic flush, ren_valid, ren_dv, ret_valid, ret_dv;
  logic [3:0] ren_sa, ren_sb, ren_dst, ret_dst;
  logic [1:0] ren_wf, ret_wf;
  logic [5:0] ret_pdst;
  logic ren_ready;
  logic [5:0] psa, psb, pfc, pfo, pdst;

  flag_rename_table u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ren_valid_i(ren_valid), .ren_src_a_i(ren_sa), .ren_src_b_i(ren_sb),
    .ren_dst_valid_i(ren_dv), .ren_dst_i(ren_dst), .ren_wflags_i(ren_wf),
    .ren_ready_o(ren_ready), .ren_psrc_a_o(psa), .ren_psrc_b_o(psb),
    .ren_pflag_c_o(pfc), .ren_pflag_o_o(pfo), .ren_pdst_o(pdst),
    .ret_valid_i(ret_valid), .ret_dst_valid_i(ret_dv), .ret_dst_i(ret_dst),
    .ret_wflags_i(ret_wf), .ret_pdst_i(ret_pdst)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // {dst_valid, dst, wflags, src_a, src_b, exp psa, psb, pfc, pfo, pdst}
  localparam logic [44:0] VEC [6] = '{
    {1'b1, 4'd1, 2'b11, 4'd2, 4'd3, 6'd2,  6'd3,  6'd0,  6'd0,  6'd16},
    {1'b1, 4'd2, 2'b10, 4'd1, 4'd0, 6'd16, 6'd0,  6'd16, 6'd16, 6'd17},
    {1'b0, 4'd0, 2'b11, 4'd2, 4'd1, 6'd17, 6'd16, 6'd16, 6'd17, 6'd18},
    {1'b1, 4'd3, 2'b00, 4'd3, 4'd1, 6'd3,  6'd16, 6'd18, 6'd18, 6'd19},
    {1'b0, 4'd0, 2'b01, 4'd0, 4'd0, 6'd0,  6'd0,  6'd18, 6'd18, 6'd20},
    {1'b1, 4'd1, 2'b00, 4'd3, 4'd3, 6'd19, 6'd19, 6'd20, 6'd18, 6'd21}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one rename request, compare outputs before the edge
  task automatic ren(input bit v, input bit dv, input logic [3:0] d, input logic [1:0] wf,
                     input logic [3:0] sa, input logic [3:0] sb, input logic [29:0] exp,
                     input bit with_pdst, input string req);
    logic [29:0] act;
    @(negedge clk);
    ren_valid = v; ren_dv = dv; ren_dst = d; ren_wf = wf; ren_sa = sa; ren_sb = sb;
    #1;
    act = {psa, psb, pfc, pfo, pdst};
    if (with_pdst) chk(act == exp, req, 32'(act), 32'(exp));
    else chk(act[29:6] == exp[29:6], req, 32'(act[29:6]), 32'(exp[29:6]));
    @(posedge clk);
    #1 ren_valid = 0; ren_dv = 0; ren_wf = 0;
  endtask

  task automatic retire(input bit dv, input logic [3:0] d, input logic [1:0] wf, input logic [5:0] p);
    @(negedge clk);
    ret_valid = 1; ret_dv = dv; ret_dst = d; ret_wf = wf; ret_pdst = p;
    @(posedge clk);
    #1 ret_valid = 0; ret_dv = 0; ret_wf = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    #1 chk(ren_ready == 1'b0, "R7 ready low during flush", 32'(ren_ready), 32'd0);
    @(posedge clk);
    #1 flush = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    flush = 0; ren_valid = 0; ren_dv = 0; ren_dst = 0; ren_wf = 0; ren_sa = 0; ren_sb = 0;
    ret_valid = 0; ret_dv = 0; ret_dst = 0; ret_wf = 0; ret_pdst = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    ren(0, 0, 0, 2'b00, 4'd15, 4'd0, {6'd15, 6'd0, 6'd0, 6'd0, 6'd16}, 1, "R1 reset map");
    chk(ren_ready == 1'b1, "R1 ready after reset", 32'(ren_ready), 32'd1);

    // R2 R3 R4: vector walk with full and partial flag writers
    foreach (VEC[i]) begin
      ren(1, VEC[i][44], VEC[i][43:40], VEC[i][39:38], VEC[i][37:34], VEC[i][33:30],
          VEC[i][29:0], 1, "R2/R3/R4 vector");
    end
    // R5 retire all in order
    foreach (VEC[i]) retire(VEC[i][44], VEC[i][43:40], VEC[i][39:38], VEC[i][5:0]);

    // R5: freed 1,2,3 come back lowest first; R6 setup
    ren(1, 1, 4'd5, 2'b11, 4'd5, 4'd5, {6'd5, 6'd5, 6'd20, 6'd18, 6'd1}, 1, "R5 freed reuse p1");
    ren(1, 1, 4'd5, 2'b00, 4'd5, 4'd5, {6'd1, 6'd1, 6'd1, 6'd1, 6'd2}, 1, "R4 int only keeps flags");
    retire(1, 4'd5, 2'b11, 6'd1);
    retire(1, 4'd5, 2'b00, 6'd2);

    // R6: p1 still holds flags, must not reappear; freed p3,p5,p16,p18,p20
    ren(1, 1, 4'd6,  2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd3},  1, "R6 alloc 3");
    ren(1, 1, 4'd7,  2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd5},  1, "R6 alloc 5");
    ren(1, 1, 4'd8,  2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd16}, 1, "R6 alloc 16");
    ren(1, 0, 4'd9,  2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd18}, 1, "R3 no-write op");
    ren(1, 1, 4'd9,  2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd18}, 1, "R3 no alloc consumed");
    ren(1, 1, 4'd10, 2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd20}, 1, "R6 alloc 20");
    ren(1, 1, 4'd11, 2'b00, 4'd5, 4'd0, {6'd2, 6'd0, 6'd1, 6'd1, 6'd22}, 1, "R6 alloc 22");

    // R7 flush restores retired state and frees unretired registers
    do_flush();
    ren(1, 1, 4'd12, 2'b00, 4'd6, 4'd5, {6'd6, 6'd2, 6'd1, 6'd1, 6'd3}, 1, "R7 restored map");

    // R8 drain free list: 46 remaining
    for (int k = 0; k < 46; k++) begin
      @(negedge clk);
      ren_valid = 1; ren_dv = 1; ren_dst = 4'd7; ren_wf = 2'b00;
      #1 chk(ren_ready == 1'b1, "R8 ready while free", 32'(ren_ready), 32'd1);
      @(posedge clk);
      #1 ren_valid = 0; ren_dv = 0;
    end
    @(negedge clk);
    ren_valid = 1; ren_dv = 1; ren_dst = 4'd8; ren_wf = 2'b11;
    #1 chk(ren_ready == 1'b0, "R8 ready low when empty", 32'(ren_ready), 32'd0);
    @(posedge clk);
    #1 ren_valid = 0; ren_dv = 0; ren_wf = 0;
    ren(0, 0, 0, 2'b00, 4'd8, 4'd7, {6'd8, 6'd63, 6'd1, 6'd1, 6'd0}, 0, "R8 stalled request ignored");

    do_flush();
    #1 chk(ren_ready == 1'b1, "R7 ready after flush", 32'(ren_ready), 32'd1);
    ren(0, 0, 0, 2'b00, 4'd7, 4'd12, {6'd7, 6'd12, 6'd1, 6'd1, 6'd3}, 1, "R7 second flush");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule